// File: doc/BRIEF.md
# Interrupt Status Aggregator with Software Set and Clear

This block gathers event pulses from a peripheral's transmit and receive datapaths into a status register, one bit per event source. Software can also force any bit on through a write-one-to-set register and drop bits through a write-one-to-clear register. An enable mask selects which status bits may raise the single level-sensitive interrupt request sent to the CPU's interrupt controller. The service routine reads the status output to find the cause.

Hardware pulses can only turn status bits on. The top status bit is a software-only interrupt with no hardware input, so software can test the whole interrupt path without a real event. Register writes arrive on a simple strobe port: a write enable, a two-bit target selector and a data word. Bus protocol handling lives outside this block.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status and enable registers read zero and the interrupt request is low.
- R2: A write with selector 1 (set) turns on every status bit whose data bit is one, visible on the status output in the cycle after the write edge. Status bits whose data bit is zero keep their value.
- R3: A write with selector 2 (clear) turns off every status bit whose data bit is one. Status bits whose data bit is zero keep their value.
- R4: A one-cycle pulse on hardware event input i sets status bit i at the next edge. The bit stays set after the pulse ends, because hardware has no way to clear it.
- R5: If a hardware event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R6: The top status bit (index NUM_HW) is the software interrupt. No hardware input can set it, and only a set write can.
- R7: A write with selector 0 loads the enable register from the data word. The interrupt request is registered and equals the OR of status AND enable in every cycle.
- R8: A write with selector 3 is reserved and changes neither the status nor the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwEvent | input | NUM_HW | Hardware event pulses, one per status bit |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Write target: 0 enable, 1 set, 2 clear, 3 reserved |
| regWrData | input | NUM_HW+1 | Write data, one bit per status bit |
| statusOut | output | NUM_HW+1 | Status register; the top bit is the software interrupt |
| enableOut | output | NUM_HW+1 | Enable mask register |
| irqOut | output | 1 | Registered level interrupt request |

## Verification
The bench builds the block with NUM_HW set to 3, which gives a four-bit status word. At that width the bench can drive every hardware input high together and confirm the software bit still stays clear. It can also clear the full word in one write and walk set, clear and enable patterns across each bit position. The narrow word also lets the bench place a hardware pulse and a clear on the same bit in one cycle, and check the result of that collision directly.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_SET    = 2'd1,
    SEL_CLEAR  = 2'd2,
    SEL_RSVD   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic enWr;
    logic setWr;
    logic clrWr;
  } regStrobe_t;

endpackage

// File: rtl/irq_status_decode.sv
module irq_status_decode
  import irq_status_pkg::*;
(
  input  logic       regWrEn,
  input  logic [1:0] regSel,
  output regStrobe_t strb
);

  regSel_e sel;

  always_comb begin
    sel        = regSel_e'(regSel);
    strb       = '0;
    if (regWrEn) begin
      unique case (sel)
        SEL_ENABLE: strb.enWr  = 1'b1;
        SEL_SET:    strb.setWr = 1'b1;
        SEL_CLEAR:  strb.clrWr = 1'b1;
        default:    strb       = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_status_datapath.sv
module irq_status_datapath
  import irq_status_pkg::*;
#(
  parameter int NUM_HW = 4,
  localparam int W = NUM_HW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [W-1:0]      wrData,
  input  logic [NUM_HW-1:0] hwEvent,
  output logic [W-1:0]      statusQ,
  output logic [W-1:0]      enableQ,
  output logic              irqQ
);

  logic [W-1:0] statusD;
  logic [W-1:0] enableD;
  logic [W-1:0] setMask;
  logic [W-1:0] clrMask;

  assign setMask = strb.setWr ? wrData : '0;
  assign clrMask = strb.clrWr ? wrData : '0;
  assign enableD = strb.enWr  ? wrData : enableQ;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      if (i < NUM_HW) begin : g_hw
        // hardware set dominates a same-cycle software clear
        assign statusD[i] = hwEvent[i] | setMask[i] | (statusQ[i] & ~clrMask[i]);
      end else begin : g_soft
        assign statusD[i] = setMask[i] | (statusQ[i] & ~clrMask[i]);
      end
      always_ff @(posedge clk) begin
        if (!rstN) statusQ[i] <= 1'b0;
        else       statusQ[i] <= statusD[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      enableQ <= enableD;
      irqQ    <= |(statusD & enableD);
    end
  end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int NUM_HW = 4,
  localparam int W = NUM_HW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_HW-1:0] hwEvent,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [W-1:0]      regWrData,
  output logic [W-1:0]      statusOut,
  output logic [W-1:0]      enableOut,
  output logic              irqOut
);

  regStrobe_t strb;

  irq_status_decode u_decode (
    .regWrEn (regWrEn),
    .regSel  (regSel),
    .strb    (strb)
  );

  irq_status_datapath #(.NUM_HW(NUM_HW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (regWrData),
    .hwEvent (hwEvent),
    .statusQ (statusOut),
    .enableQ (enableOut),
    .irqQ    (irqOut)
  );

endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int NUM_HW = 4,
  localparam int W = NUM_HW + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_HW-1:0] hwEvent,
  input logic              regWrEn,
  input logic [1:0]        regSel,
  input logic [W-1:0]      regWrData,
  input logic [W-1:0]      statusOut,
  input logic [W-1:0]      enableOut,
  input logic              irqOut
);

  // R2
  set_bits_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd1) |=> ((statusOut & $past(regWrData)) == $past(regWrData)));

  // R2
  set_zeros_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd1 && hwEvent == '0)
      |=> ((statusOut & ~$past(regWrData)) == ($past(statusOut) & ~$past(regWrData))));

  // R3
  clear_bits_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd2)
      |=> ((statusOut & $past(regWrData) & ~{1'b0, $past(hwEvent)}) == '0));

  // R4 R5
  hw_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hwEvent != '0) |=> ((statusOut[NUM_HW-1:0] & $past(hwEvent)) == $past(hwEvent)));

  // R6
  soft_only_sw_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[W-1]) |-> $past(regWrEn && regSel == 2'd1 && regWrData[W-1]));

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(statusOut & enableOut));

  // R8
  rsvd_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd3 && hwEvent == '0) |=> ($stable(statusOut) && $stable(enableOut)));

endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.NUM_HW(NUM_HW)) chk (.*);

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;

  localparam int NUM_HW = 3;
  localparam int W = NUM_HW + 1;
  localparam int EW = 2 * W + 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_HW-1:0] hwEvent = '0;
  logic              regWrEn = 1'b0;
  logic [1:0]        regSel = 2'd0;
  logic [W-1:0]      regWrData = '0;
  logic [W-1:0]      statusOut;
  logic [W-1:0]      enableOut;
  logic              irqOut;

  int checks = 0;
  int errors = 0;

  logic [EW-1:0] expQ[$];
  string         tagQ[$];

  logic [W-1:0] mStat = '0;
  logic [W-1:0] mEn = '0;

  always #4 clk = ~clk;

  irq_status_ctrl #(.NUM_HW(NUM_HW)) uut (
    .clk(clk), .rstN(rstN), .hwEvent(hwEvent), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .statusOut(statusOut),
    .enableOut(enableOut), .irqOut(irqOut)
  );

  // driver: apply one cycle of stimulus, push the expected result
  task automatic step(input logic [NUM_HW-1:0] hw, input logic we,
                      input logic [1:0] sel, input logic [W-1:0] data,
                      input string tag);
    logic [W-1:0] setM, clrM;
    hwEvent = hw; regWrEn = we; regSel = sel; regWrData = data;
    setM = (we && sel == 2'd1) ? data : '0;
    clrM = (we && sel == 2'd2) ? data : '0;
    if (we && sel == 2'd0) mEn = data;
    mStat = (mStat & ~clrM) | setM | {1'b0, hw};
    @(posedge clk);
    expQ.push_back({mStat, mEn, |(mStat & mEn)});
    tagQ.push_back(tag);
    @(negedge clk);
    hwEvent = '0; regWrEn = 1'b0; regSel = 2'd0; regWrData = '0;
  endtask

  // monitor: compare outputs against the scoreboard away from the edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [EW-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if ({statusOut, enableOut, irqOut} !== e) begin
        errors++;
        $display("FAIL %s: got status=%b enable=%b irq=%b expected status=%b enable=%b irq=%b",
                 t, statusOut, enableOut, irqOut, e[EW-1 -: W], e[W -: W], e[0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    checks++;
    if (statusOut !== '0 || enableOut !== '0 || irqOut !== 1'b0) begin
      errors++;
      $display("FAIL R1: got status=%b enable=%b irq=%b expected all zero",
               statusOut, enableOut, irqOut);
    end
    rstN = 1'b1;
    @(negedge clk);

    step('0, 1'b1, 2'd1, 4'b0101, "R2");   // set two bits
    step('0, 1'b1, 2'd1, 4'b0010, "R2");   // zero bits keep value
    step('0, 1'b1, 2'd2, 4'b0001, "R3");   // clear one bit
    step('0, 1'b1, 2'd2, 4'b0000, "R3");   // clear with zeros: no change
    step('0, 1'b1, 2'd0, 4'b0100, "R7");   // enable bit2 -> irq
    step('0, 1'b1, 2'd2, 4'b0100, "R7");   // clear bit2 -> irq drops
    step('0, 1'b1, 2'd2, 4'b0111, "R3");   // clear all hw bits
    step(3'b001, 1'b0, 2'd0, 4'b0000, "R4"); // hw pulse sets bit0
    step('0, 1'b0, 2'd0, 4'b0000, "R4");   // bit0 persists
    step(3'b010, 1'b1, 2'd2, 4'b0010, "R5"); // hw set beats clear
    step(3'b111, 1'b0, 2'd0, 4'b0000, "R6"); // soft bit stays clear
    step('0, 1'b1, 2'd0, 4'b1000, "R7");   // enable soft bit only: irq low
    step('0, 1'b1, 2'd1, 4'b1000, "R6");   // software sets soft bit -> irq
    step('0, 1'b1, 2'd3, 4'b1111, "R8");   // reserved write ignored
    step('0, 1'b1, 2'd3, 4'b0000, "R8");
    step('0, 1'b1, 2'd0, 4'b1111, "R7");
    step('0, 1'b1, 2'd2, 4'b1111, "R3");   // clear everything -> irq low
    step(3'b100, 1'b0, 2'd0, 4'b0000, "R7"); // hw event with enable -> irq

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule